// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block turns one internal transfer request into a single asynchronous NAND flash bus cycle. A request names its kind (command, address or data), the direction, the target chip-select and the write data. The sequencer then walks the access through setup, strobe and hold phases. Each phase length is an 8-bit cycle count taken from one of two timing registers. Command and address cycles use the attribute set. Data cycles use the common set. It drives the chip enables, the latch enables, the two strobes and the output enable of the data bus, and it returns the sampled read word.

A small register port sets up the controller. One control word holds a global enable, a bank enable, a ready/busy stall enable, the bus width and two 4-bit turnaround delays. These delays hold off a data read that follows a command or address cycle. When the stall enable is set, the strobe phase is stretched for as long as the flash reports busy on its ready/busy pin. A one-cycle done pulse ends every access, and the sequencer is then free for the next request.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset the control word (address 0) reads 0x00000FF0, and both timing words (address 1 common, address 2 attribute) read 0x0A0A0A0A. All chip enables and both strobes are high, both latch enables and the data output enable are low, and req_ready is low.
- R2: A request is accepted only while the sequencer is idle with the global enable (control bit 31) and the bank enable (control bit 0) both set. While either bit is clear, req_valid produces no bus activity and no done pulse.
- R3: A timing word holds setup in bits 7:0, strobe length in 15:8, hold in 23:16 and the high-Z delay in 31:24. The selected chip enable is low for setup+strobe+hold cycles. The strobe is low for exactly the strobe count, preceded by the setup count and followed by the hold count.
- R4: A programmed setup, strobe or hold count of 0 behaves as 1.
- R5: Command (req_kind 0) and address (req_kind 1) accesses take their counts from the attribute word. Data accesses (req_kind 2 or 3) take them from the common word.
- R6: nand_cle is high for the whole chip-enable window of a command access, and nand_ale for that of an address access. Neither is high for a data access.
- R7: For a write (req_rd 0), nand_we_n is the strobe; for a read, nand_re_n is. The other strobe stays high. Only nand_ce_n[req_cs] goes low.
- R8: For a write, nand_dq_oe rises when the high-Z count of cycles has elapsed since the first setup cycle, and it stays high through the last hold cycle. If the count reaches the end of the access, it never rises. It never rises for a read.
- R9: With the width bit (control bit 2) at 1, data accesses drive and return all 16 bits. With it at 0, and for every command or address access, bits 15:8 of the driven word are zero and a returned word is zero-extended from bits 7:0.
- R10: A read returns on rdata the value present on nand_dq_in during the last strobe cycle, valid from the done pulse onward.
- R11: done is high for exactly one cycle, the first cycle after the last hold cycle. req_ready is high in that cycle.
- R12: A data read that directly follows a command access waits the CLE turnaround count (control bits 7:4) in cycles before setup begins. After an address access it waits the ALE turnaround count (control bits 11:8). All other accesses start setup in the cycle after acceptance.
- R13: With the stall enable (control bit 1) set, the strobe phase does not end while nand_rb, seen through a two-flop synchronizer, is low.
- R14: The timing counts are captured when a request is accepted. Rewriting a timing word during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index: 0 control, 1 common timing, 2 attribute timing |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle and enabled |
| req_kind | input | 2 | 0 command, 1 address, 2 or 3 data |
| req_rd | input | 1 | 1 read, 0 write |
| req_cs | input | log2(NUM_CS) | Target chip-select index |
| req_wdata | input | 16 | Word to drive on a write |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 16 | Word captured by the last read |
| nand_ce_n | output | NUM_CS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_out | output | 16 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus input value |
| nand_rb | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The assertions take for granted that reset is applied before the first access. They also expect the request fields to be steady in the cycle req_valid is sampled, and nand_rb to change slowly enough for the synchronizer. The pin properties rest on that: strobes mutually exclusive, one chip enable at a time, latch enables exclusive, and no start while busy. The stimulus drives every input half a clock away from the sampling edge. It raises req_valid only for a single accepted cycle, or holds it while the block is disabled. It moves nand_rb only while a stalled strobe phase is in progress, with many cycles on either side.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int DQ_W       = 16;
    localparam int CNT_W      = 8;
    localparam int TURN_W     = 4;
    localparam int CFG_W      = 32;
    localparam int CFG_ADDR_W = 2;

    localparam logic [CFG_ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [CFG_ADDR_W-1:0] REG_COM  = 2'd1;
    localparam logic [CFG_ADDR_W-1:0] REG_ATT  = 2'd2;

    localparam logic [CFG_W-1:0] CTRL_RESET   = 32'h0000_0FF0;
    localparam logic [CFG_W-1:0] TIMING_RESET = 32'h0A0A_0A0A;

    typedef enum logic [1:0] {
        ACC_CMD  = 2'd0,
        ACC_ADDR = 2'd1,
        ACC_DATA = 2'd2
    } acc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_TURN  = 3'd1,
        PH_SETUP = 3'd2,
        PH_STRB  = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;

    // Field order matches the timing word: hiz 31:24 ... setup 7:0
    typedef struct packed {
        logic [CNT_W-1:0] hiz;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] strobe;
        logic [CNT_W-1:0] setup;
    } phase_set_t;

    typedef struct packed {
        logic              gen;
        logic              wide;
        logic              stall_en;
        logic              bank_en;
        logic [TURN_W-1:0] cle_turn;
        logic [TURN_W-1:0] ale_turn;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    function automatic logic [CNT_W-1:0] last_index(input logic [CNT_W-1:0] v);
        return at_least_one(v) - CNT_W'(1);
    endfunction

    function automatic acc_kind_e to_kind(input logic [1:0] code);
        case (code)
            2'd0:    return ACC_CMD;
            2'd1:    return ACC_ADDR;
            default: return ACC_DATA;
        endcase
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [CFG_W-1:0] w);
        ctrl_t c;
        c.gen      = w[31];
        c.wide     = w[2];
        c.stall_en = w[1];
        c.bank_en  = w[0];
        c.cle_turn = w[7:4];
        c.ale_turn = w[11:8];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [CFG_W-1:0] w;
        w       = '0;
        w[31]   = c.gen;
        w[2]    = c.wide;
        w[1]    = c.stall_en;
        w[0]    = c.bank_en;
        w[7:4]  = c.cle_turn;
        w[11:8] = c.ale_turn;
        return w;
    endfunction

    function automatic logic [DQ_W-1:0] fit_width(input logic [DQ_W-1:0] v, input logic full);
        return full ? v : {{(DQ_W-8){1'b0}}, v[7:0]};
    endfunction

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output logic [CFG_W-1:0]      cfg_rdata,
    output ctrl_t                 ctrl,
    output phase_set_t            com_set,
    output phase_set_t            att_set
);
    localparam int NUM_SETS = 2;

    ctrl_t      ctrl_q;
    phase_set_t set_q [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= word_to_ctrl(CTRL_RESET);
        end else if (cfg_we && cfg_addr == REG_CTRL) begin
            ctrl_q <= word_to_ctrl(cfg_wdata);
        end
    end

    // set 0 is the common word, set 1 the attribute word
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        localparam logic [CFG_ADDR_W-1:0] MY_ADDR = REG_COM + CFG_ADDR_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                set_q[g] <= phase_set_t'(TIMING_RESET);
            end else if (cfg_we && cfg_addr == MY_ADDR) begin
                set_q[g] <= phase_set_t'(cfg_wdata);
            end
        end
    end

    always_comb begin
        case (cfg_addr)
            REG_CTRL: cfg_rdata = ctrl_to_word(ctrl_q);
            REG_COM:  cfg_rdata = set_q[0];
            REG_ATT:  cfg_rdata = set_q[1];
            default:  cfg_rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign com_set = set_q[0];
    assign att_set = set_q[1];

endmodule

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int CS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  phase_set_t       com_set,
    input  phase_set_t       att_set,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_rd,
    input  logic [CS_W-1:0]  req_cs,
    input  logic [DQ_W-1:0]  req_wdata,
    input  logic             rb_ready,
    input  logic [DQ_W-1:0]  dq_in,
    output logic             req_ready,
    output logic             done,
    output logic [DQ_W-1:0]  rdata,
    output phase_e           phase,
    output acc_kind_e        cur_kind,
    output logic             cur_rd,
    output logic [CS_W-1:0]  cur_cs,
    output logic [DQ_W-1:0]  cur_wdata,
    output logic             cur_wide,
    output logic [CNT_W-1:0] elapsed,
    output logic [CNT_W-1:0] hiz_len
);
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] elap_q;
    logic             done_q;
    logic [DQ_W-1:0]  rdata_q;
    acc_kind_e        last_q;
    phase_set_t       tim_q;
    acc_kind_e        kind_q;
    logic             rd_q;
    logic [CS_W-1:0]  cs_q;
    logic [DQ_W-1:0]  wd_q;
    logic             wide_q;

    acc_kind_e        in_kind;
    phase_set_t       in_set;
    logic [TURN_W-1:0] turn_len;
    logic             accept;
    logic             strobe_go;
    logic [CNT_W-1:0] elap_next;

    assign req_ready = (phase_q == PH_IDLE) && ctrl.gen && ctrl.bank_en;
    assign accept    = req_valid && req_ready;
    assign in_kind   = to_kind(req_kind);
    assign in_set    = (in_kind == ACC_DATA) ? com_set : att_set;
    assign strobe_go = !ctrl.stall_en || rb_ready;
    assign elap_next = (elap_q == '1) ? elap_q : elap_q + CNT_W'(1);

    always_comb begin
        turn_len = '0;
        if (in_kind == ACC_DATA && req_rd) begin
            if (last_q == ACC_CMD) begin
                turn_len = ctrl.cle_turn;
            end else if (last_q == ACC_ADDR) begin
                turn_len = ctrl.ale_turn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            elap_q  <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
            last_q  <= ACC_DATA;
            tim_q   <= phase_set_t'(TIMING_RESET);
            kind_q  <= ACC_DATA;
            rd_q    <= 1'b0;
            cs_q    <= '0;
            wd_q    <= '0;
            wide_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        tim_q  <= in_set;
                        kind_q <= in_kind;
                        last_q <= in_kind;
                        rd_q   <= req_rd;
                        cs_q   <= req_cs;
                        wd_q   <= req_wdata;
                        wide_q <= ctrl.wide;
                        elap_q <= '0;
                        if (turn_len != '0) begin
                            phase_q <= PH_TURN;
                            cnt_q   <= CNT_W'(turn_len) - CNT_W'(1);
                        end else begin
                            phase_q <= PH_SETUP;
                            cnt_q   <= last_index(in_set.setup);
                        end
                    end
                end
                PH_TURN: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= last_index(tim_q.setup);
                        elap_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_SETUP: begin
                    elap_q <= elap_next;
                    if (cnt_q == '0) begin
                        phase_q <= PH_STRB;
                        cnt_q   <= last_index(tim_q.strobe);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_STRB: begin
                    elap_q <= elap_next;
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end else if (strobe_go) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= last_index(tim_q.hold);
                        if (rd_q) begin
                            rdata_q <= fit_width(dq_in, wide_q && kind_q == ACC_DATA);
                        end
                    end
                end
                PH_HOLD: begin
                    elap_q <= elap_next;
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign done      = done_q;
    assign rdata     = rdata_q;
    assign phase     = phase_q;
    assign cur_kind  = kind_q;
    assign cur_rd    = rd_q;
    assign cur_cs    = cs_q;
    assign cur_wdata = wd_q;
    assign cur_wide  = wide_q;
    assign elapsed   = elap_q;
    assign hiz_len   = tim_q.hiz;

endmodule

// File: rtl/nand_seq_pins.sv
module nand_seq_pins
    import nand_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2
) (
    input  phase_e            phase,
    input  acc_kind_e         kind,
    input  logic              rd,
    input  logic [CS_W-1:0]   cs,
    input  logic [DQ_W-1:0]   wdata,
    input  logic              wide,
    input  logic [CNT_W-1:0]  elapsed,
    input  logic [CNT_W-1:0]  hiz_len,
    output logic [NUM_CS-1:0] ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe
);
    logic active;
    logic strobing;

    assign active   = (phase == PH_SETUP) || (phase == PH_STRB) || (phase == PH_HOLD);
    assign strobing = (phase == PH_STRB);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
        assign ce_n[g] = !(active && cs == CS_W'(g));
    end

    assign cle    = active && (kind == ACC_CMD);
    assign ale    = active && (kind == ACC_ADDR);
    assign we_n   = !(strobing && !rd);
    assign re_n   = !(strobing && rd);
    assign dq_out = fit_width(wdata, wide && kind == ACC_DATA);
    assign dq_oe  = active && !rd && (elapsed >= hiz_len);

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int RB_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_addr,
    input  logic [31:0]               cfg_wdata,
    output logic [31:0]               cfg_rdata,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [1:0]                req_kind,
    input  logic                      req_rd,
    input  logic [$clog2(NUM_CS)-1:0] req_cs,
    input  logic [15:0]               req_wdata,
    output logic                      done,
    output logic [15:0]               rdata,
    output logic [NUM_CS-1:0]         nand_ce_n,
    output logic                      nand_cle,
    output logic                      nand_ale,
    output logic                      nand_we_n,
    output logic                      nand_re_n,
    output logic [15:0]               nand_dq_out,
    output logic                      nand_dq_oe,
    input  logic [15:0]               nand_dq_in,
    input  logic                      nand_rb
);
    localparam int CS_W = $clog2(NUM_CS);

    ctrl_t            ctrl;
    phase_set_t       com_set;
    phase_set_t       att_set;
    logic             rb_ready;
    phase_e           phase;
    acc_kind_e        cur_kind;
    logic             cur_rd;
    logic [CS_W-1:0]  cur_cs;
    logic [DQ_W-1:0]  cur_wdata;
    logic             cur_wide;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] hiz_len;

    nand_seq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctrl      (ctrl),
        .com_set   (com_set),
        .att_set   (att_set)
    );

    nand_seq_sync #(.STAGES(RB_STAGES)) u_rb_sync (
        .clk (clk),
        .rst (rst),
        .d   (nand_rb),
        .q   (rb_ready)
    );

    nand_seq_fsm #(.CS_W(CS_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .com_set   (com_set),
        .att_set   (att_set),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_rd    (req_rd),
        .req_cs    (req_cs),
        .req_wdata (req_wdata),
        .rb_ready  (rb_ready),
        .dq_in     (nand_dq_in),
        .req_ready (req_ready),
        .done      (done),
        .rdata     (rdata),
        .phase     (phase),
        .cur_kind  (cur_kind),
        .cur_rd    (cur_rd),
        .cur_cs    (cur_cs),
        .cur_wdata (cur_wdata),
        .cur_wide  (cur_wide),
        .elapsed   (elapsed),
        .hiz_len   (hiz_len)
    );

    nand_seq_pins #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_pins (
        .phase   (phase),
        .kind    (cur_kind),
        .rd      (cur_rd),
        .cs      (cur_cs),
        .wdata   (cur_wdata),
        .wide    (cur_wide),
        .elapsed (elapsed),
        .hiz_len (hiz_len),
        .ce_n    (nand_ce_n),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .dq_out  (nand_dq_out),
        .dq_oe   (nand_dq_oe)
    );

endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              done,
    input logic [NUM_CS-1:0] nand_ce_n,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic              nand_dq_oe
);
    // R7: the two strobes are never low together
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    // R7: at most one chip enable is low
    a_r7_one_ce: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~nand_ce_n));

    // R7: a strobe only moves inside a chip-enable window
    a_r7_strobe_in_ce: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> (nand_ce_n != '1));

    // R6: command and address latch enables are exclusive
    a_r6_latch_excl: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    // R8: the bus is never driven while the read strobe is low
    a_r8_oe_not_on_read: assert property (@(posedge clk) disable iff (rst)
        nand_dq_oe |-> nand_re_n);

    // R11: done lasts one cycle and comes with all chip enables high
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (nand_ce_n == '1));

    // R2: no new request is taken while an access holds a chip enable
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (nand_ce_n != '1) |-> !req_ready);

endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .done       (done),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_cycle_seq_bench.sv
module nand_cycle_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic        req_rd = 1'b0;
    logic [1:0]  req_cs = 2'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        done;
    logic [15:0] rdata;
    logic [3:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = 16'd0;
    logic        nand_rb = 1'b1;

    always #2 clk = ~clk;

    nand_cycle_seq u_nand_cycle_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_rd(req_rd), .req_cs(req_cs), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  kind;
        logic        rd;
        logic [1:0]  cs;
        logic        wide;
        logic [15:0] wd;
        logic [15:0] din;
        logic [31:0] tim;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 2'd0, 1'b0, 16'h0070, 16'h0000, 32'h02030201},
        '{2'd1, 1'b0, 2'd1, 1'b0, 16'h1234, 16'h0000, 32'h01020402},
        '{2'd2, 1'b1, 2'd1, 1'b0, 16'h0000, 16'hA55A, 32'h00020301},
        '{2'd0, 1'b0, 2'd2, 1'b1, 16'hAB90, 16'h0000, 32'h00010101},
        '{2'd2, 1'b1, 2'd2, 1'b1, 16'h0000, 16'hC3E1, 32'h00010202},
        '{2'd2, 1'b0, 2'd3, 1'b1, 16'hBEEF, 16'h0000, 32'h03020203},
        '{2'd2, 1'b0, 2'd0, 1'b0, 16'hBEEF, 16'h0000, 32'h00000000},
        '{2'd2, 1'b1, 2'd3, 1'b0, 16'h0000, 16'h7788, 32'h00040103},
        '{2'd1, 1'b0, 2'd0, 1'b0, 16'h00C4, 16'h0000, 32'h0A010101},
        '{2'd3, 1'b0, 2'd1, 1'b1, 16'h0001, 16'h0000, 32'h01010101}
    };

    localparam int CLE_T = 3;
    localparam int ALE_T = 5;
    localparam logic [31:0] CTRL_ON = 32'h8000_0531;

    int m_pre, m_setup, m_strb, m_hold, m_oe_first, m_oe_cnt, m_dq, m_rdata;
    bit m_ctl_ok, m_ce_ok, m_other_ok, m_done;
    int last_kind = 2;

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_acc(input logic [1:0] kind, input logic rd, input logic [1:0] cs,
                           input logic [15:0] wd, input bit poke);
        int n;
        bit data_k;
        data_k = (kind >= 2'd2);
        m_pre = 0; m_setup = 0; m_strb = 0; m_hold = 0; m_oe_first = -1; m_oe_cnt = 0;
        m_dq = 0; m_rdata = 0; m_ctl_ok = 1; m_ce_ok = 1; m_other_ok = 1; m_done = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_rd = rd; req_cs = cs; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin
                m_done = 1; m_rdata = int'(rdata);
                chk(req_ready == 1'b1, "R11 ready with done", int'(req_ready), 1);
                break;
            end
            if (nand_ce_n == 4'hF) begin
                if (m_setup == 0 && m_strb == 0) m_pre++;
            end else begin
                if (nand_ce_n != ~(4'b0001 << cs)) m_ce_ok = 0;
                if (nand_cle != (kind == 2'd0) || nand_ale != (kind == 2'd1)) m_ctl_ok = 0;
                if ((rd ? nand_we_n : nand_re_n) == 1'b0) m_other_ok = 0;
                if ((rd ? nand_re_n : nand_we_n) == 1'b0) begin
                    m_strb++; m_dq = int'(nand_dq_out);
                end else if (m_strb == 0) begin
                    m_setup++;
                end else begin
                    m_hold++;
                end
                if (nand_dq_oe) begin
                    if (m_oe_first < 0) m_oe_first = n;
                    m_oe_cnt++;
                end
                n++;
            end
            if (poke && n == 1) begin
                cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h00090909;
            end else if (poke && n == 2) begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R11 done one cycle", int'(done), 0);
        if (!data_k || !rd) begin end
        last_kind = int'(kind);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        cfg_addr = 2'd0; #1;
        chk(cfg_rdata == 32'h0000_0FF0, "R1 ctrl reset", int'(cfg_rdata), 32'h0FF0);
        cfg_addr = 2'd1; #1;
        chk(cfg_rdata == 32'h0A0A_0A0A, "R1 common reset", int'(cfg_rdata), 32'h0A0A0A0A);
        cfg_addr = 2'd2; #1;
        chk(cfg_rdata == 32'h0A0A_0A0A, "R1 attribute reset", int'(cfg_rdata), 32'h0A0A0A0A);
        chk(nand_ce_n == 4'hF && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
            "R1 idle pins", int'({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}),
            32'h0F << 5 | 32'h18);
        chk(req_ready == 1'b0, "R1 not ready", int'(req_ready), 0);

        // R2 disabled: global off, then bank off
        for (int pass = 0; pass < 2; pass++) begin
            int act;
            cfg_write(2'd0, pass == 0 ? 32'h0000_0531 : 32'h8000_0530);
            act = 0;
            @(negedge clk);
            req_valid = 1'b1; req_kind = 2'd2; req_rd = 1'b0; req_cs = 2'd0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (nand_ce_n != 4'hF || done || req_ready) act++;
            end
            req_valid = 1'b0;
            chk(act == 0, "R2 no access while disabled", act, 0);
        end
        cfg_write(2'd0, CTRL_ON);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready when enabled", int'(req_ready), 1);

        // vector walk: R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
        for (int v = 0; v < NV; v++) begin
            vec_t e;
            bit data_k;
            int xs, xw, xh, xz, xtot, xpre, xdq;
            e = VEC[v];
            data_k = (e.kind >= 2'd2);
            cfg_write(2'd0, CTRL_ON | (32'(e.wide) << 2));
            cfg_write(data_k ? 2'd1 : 2'd2, e.tim);
            cfg_write(data_k ? 2'd2 : 2'd1, 32'h05050505);
            nand_dq_in = e.din;
            xs = eff(e.tim[7:0]); xw = eff(e.tim[15:8]); xh = eff(e.tim[23:16]);
            xz = int'(e.tim[31:24]); xtot = xs + xw + xh;
            xpre = (data_k && e.rd) ? (last_kind == 0 ? CLE_T : (last_kind == 1 ? ALE_T : 0)) : 0;
            xdq = (data_k && e.wide) ? int'(e.wd) : int'(e.wd & 16'h00FF);
            run_acc(e.kind, e.rd, e.cs, e.wd, 1'b0);
            chk(m_done == 1, "R11 done seen", int'(m_done), 1);
            chk(m_pre == xpre, "R12 turnaround gap", m_pre, xpre);
            chk(m_setup == xs, "R3 R4 R5 setup length", m_setup, xs);
            chk(m_strb == xw, "R3 R4 R5 strobe length", m_strb, xw);
            chk(m_hold == xh, "R3 R4 R5 hold length", m_hold, xh);
            chk(m_ctl_ok == 1, "R6 latch enables", int'(m_ctl_ok), 1);
            chk(m_ce_ok == 1 && m_other_ok == 1, "R7 chip enable and strobe", int'({m_ce_ok, m_other_ok}), 3);
            if (e.rd) begin
                chk(m_oe_cnt == 0, "R8 no drive on read", m_oe_cnt, 0);
                chk(m_rdata == ((data_k && e.wide) ? int'(e.din) : int'(e.din & 16'h00FF)),
                    "R10 R9 read data", m_rdata,
                    (data_k && e.wide) ? int'(e.din) : int'(e.din & 16'h00FF));
            end else begin
                chk(m_dq == xdq, "R9 driven word", m_dq, xdq);
                if (xz < xtot) begin
                    chk(m_oe_first == xz && m_oe_cnt == xtot - xz, "R8 output enable window",
                        m_oe_first, xz);
                end else begin
                    chk(m_oe_cnt == 0, "R8 output enable never", m_oe_cnt, 0);
                end
            end
        end

        // R14 snapshot: rewrite common word during setup
        cfg_write(2'd0, CTRL_ON);
        cfg_write(2'd1, 32'h00010202);
        run_acc(2'd2, 1'b0, 2'd1, 16'h0055, 1'b1);
        chk(m_setup == 2 && m_strb == 2 && m_hold == 1, "R14 counts held at accept",
            m_strb, 2);
        cfg_addr = 2'd1; #1;
        chk(cfg_rdata == 32'h00090909, "R14 rewrite landed", int'(cfg_rdata), 32'h00090909);

        // R13 ready/busy stall
        begin
            int lows, waited;
            bit seen_done;
            cfg_write(2'd0, CTRL_ON | 32'h2);
            cfg_write(2'd1, 32'h00010201);
            nand_rb = 1'b0;
            repeat (4) @(negedge clk);
            req_valid = 1'b1; req_kind = 2'd2; req_rd = 1'b0; req_cs = 2'd2; req_wdata = 16'h0011;
            @(negedge clk);
            req_valid = 1'b0;
            lows = 0; seen_done = 0;
            for (int i = 0; i < 40; i++) begin
                if (!nand_we_n) lows++;
                if (done) seen_done = 1;
                @(negedge clk);
            end
            chk(nand_we_n == 1'b0 && !seen_done, "R13 strobe held while busy",
                int'({nand_we_n, seen_done}), 0);
            nand_rb = 1'b1;
            waited = 0;
            while (!done && waited < 50) begin
                if (!nand_we_n) lows++;
                waited++;
                @(negedge clk);
            end
            chk(done == 1'b1 && lows >= 39, "R13 release after ready", lows, 39);
            last_kind = 2;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule